// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline with the stages fetch, decode, execute, memory and writeback. Each cycle it compares the source register fields of the instruction now in decode against the destination of the instruction now in execute. When that execute-stage instruction is a load, and a source that decode actually reads names the load's destination, the value cannot be forwarded in time. The unit then stalls for one cycle.

During a stall the unit holds the fetch address and the fetch/decode pipeline register, so no fetched instruction is lost. It also loads zeros into the execute-stage control bundle that it owns, which sends a bubble down toward execute, memory and writeback. On the next cycle the load has moved into the memory stage, the held instruction goes ahead, and the ordinary forwarding path supplies the loaded value.

The unit owns the decode-to-execute copy of the control bundle, the load flag and the destination field. The hazard check therefore always sees its own registered state, and a bubble it inserts can never trigger a second stall.

Top module: `ldu_stall_unit`

## Requirements
- R1: While reset is asserted and after its release, `pc_we` and `fd_we` are 1, and `ex_ctrl`, `ex_mem_read` and `ex_dst` are all zero.
- R2: A stall exists when all of the following hold: `ex_mem_read` is 1, `ex_dst` is nonzero, and either (`id_uses_rs` is 1 and `id_rs` equals `ex_dst`) or (`id_uses_rt` is 1 and `id_rt` equals `ex_dst`). In that same cycle `pc_we` and `fd_we` are both 0.
- R3: At the clock edge that ends a stall cycle, `ex_ctrl`, `ex_mem_read` and `ex_dst` all become zero.
- R4: In a cycle with no stall, `pc_we` and `fd_we` are 1. At the next clock edge, `ex_ctrl`, `ex_mem_read` and `ex_dst` take the values of `id_ctrl`, `id_mem_read` and `id_dst`.
- R5: When `ex_dst` is register 0, no stall occurs, even if a decode source field is also 0.
- R6: A source comparison counts only when its uses flag is 1. A match on `id_rt` while `id_uses_rt` is 0 causes no stall, and the same holds for `id_rs` while `id_uses_rs` is 0.
- R7: Each load-use pair inserts exactly one bubble. The cycle after a stall never stalls, even when the decode inputs are unchanged.
- R8: When `ex_mem_read` is 0, no stall occurs, whatever the register fields are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_rs | input | REG_AW | First source register of the instruction in decode |
| id_rt | input | REG_AW | Second source register of the instruction in decode |
| id_uses_rs | input | 1 | The decode instruction reads `id_rs` |
| id_uses_rt | input | 1 | The decode instruction reads `id_rt` |
| id_mem_read | input | 1 | The decode instruction is a load |
| id_dst | input | REG_AW | Destination register of the decode instruction |
| id_ctrl | input | CTRL_W | Remaining control bundle of the decode instruction |
| pc_we | output | 1 | Fetch address update enable (0 during a stall) |
| fd_we | output | 1 | Fetch/decode register write enable (0 during a stall) |
| ex_mem_read | output | 1 | Registered load flag of the instruction in execute |
| ex_dst | output | REG_AW | Registered destination of the instruction in execute |
| ex_ctrl | output | CTRL_W | Registered control bundle of the instruction in execute |

## Verification
The assertions assume that the surrounding pipeline holds the decode inputs steady after a stall, because the fetch/decode register is frozen. They also assume that the uses flags reflect the real operand needs of the decode instruction. The stimulus follows the same rules: each stall cycle is followed by the same decode inputs again, and the uses flags are set the way a real decoder would set them. The only exceptions are the rows meant to show that a cleared flag masks a register match. Register 0 and non-load producers are driven with matching fields, so the cases that must not stall are covered.

// File: rtl/ldu_stall_unit.sv
module ldu_stall_unit #(
  parameter int REG_AW = 5,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_uses_rs,
  input  logic              id_uses_rt,
  input  logic              id_mem_read,
  input  logic [REG_AW-1:0] id_dst,
  input  logic [CTRL_W-1:0] id_ctrl,
  output logic              pc_we,
  output logic              fd_we,
  output logic              ex_mem_read,
  output logic [REG_AW-1:0] ex_dst,
  output logic [CTRL_W-1:0] ex_ctrl
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic dst_live;
  logic rs_hit;
  logic rt_hit;
  logic hazard;

  assign dst_live = ex_mem_read && (ex_dst != ZERO_REG);
  assign rs_hit   = id_uses_rs && (id_rs == ex_dst);
  assign rt_hit   = id_uses_rt && (id_rt == ex_dst);
  assign hazard   = dst_live && (rs_hit || rt_hit);

  assign pc_we = !hazard;
  assign fd_we = !hazard;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_mem_read <= 1'b0;
      ex_dst      <= '0;
      ex_ctrl     <= '0;
    end else if (hazard) begin
      ex_mem_read <= 1'b0;
      ex_dst      <= '0;
      ex_ctrl     <= '0;
    end else begin
      ex_mem_read <= id_mem_read;
      ex_dst      <= id_dst;
      ex_ctrl     <= id_ctrl;
    end
  end

  // R3
  bubble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> (ex_ctrl == '0) && !ex_mem_read && (ex_dst == '0));

  // R7
  single_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> pc_we);

  // R5
  zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0) |-> pc_we);

  // R8
  no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_mem_read |-> pc_we);

  // R4
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> (ex_ctrl == $past(id_ctrl)) && (ex_dst == $past(id_dst))
              && (ex_mem_read == $past(id_mem_read)));

  // R2
  hold_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we == fd_we);

endmodule

// File: tb/ldu_stall_unit_tb_top.sv
module ldu_stall_unit_tb_top;
  localparam int AW = 5;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] id_rs = '0, id_rt = '0, id_dst = '0;
  logic id_uses_rs = 1'b0, id_uses_rt = 1'b0, id_mem_read = 1'b0;
  logic [CW-1:0] id_ctrl = '0;
  logic pc_we, fd_we, ex_mem_read;
  logic [AW-1:0] ex_dst;
  logic [CW-1:0] ex_ctrl;

  always #10 clk = ~clk;

  ldu_stall_unit #(.REG_AW(AW), .CTRL_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
    .id_uses_rs(id_uses_rs), .id_uses_rt(id_uses_rt),
    .id_mem_read(id_mem_read), .id_dst(id_dst), .id_ctrl(id_ctrl),
    .pc_we(pc_we), .fd_we(fd_we), .ex_mem_read(ex_mem_read),
    .ex_dst(ex_dst), .ex_ctrl(ex_ctrl));

  typedef struct {
    bit          stall;
    logic        mr;
    logic [AW-1:0] dst;
    logic [CW-1:0] ctrl;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic          m_mr = 1'b0;
  logic [AW-1:0] m_dst = '0;
  logic [CW-1:0] m_ctrl = '0;

  task automatic step(input logic [AW-1:0] rs, input logic [AW-1:0] rt,
                      input logic urs, input logic urt, input logic mr,
                      input logic [AW-1:0] dst, input logic [CW-1:0] ctrl,
                      input string tag);
    item_t it;
    @(negedge clk);
    #1;
    id_rs = rs; id_rt = rt; id_uses_rs = urs; id_uses_rt = urt;
    id_mem_read = mr; id_dst = dst; id_ctrl = ctrl;
    it.stall = m_mr && (m_dst != 0) && ((urs && rs == m_dst) || (urt && rt == m_dst));
    it.mr   = it.stall ? 1'b0 : mr;
    it.dst  = it.stall ? '0 : dst;
    it.ctrl = it.stall ? '0 : ctrl;
    it.tag  = tag;
    q.push_back(it);
    m_mr = it.mr; m_dst = it.dst; m_ctrl = it.ctrl;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        it = q.pop_front();
        total++;
        if ((pc_we !== !it.stall) || (fd_we !== !it.stall)) begin
          bad++;
          $display("FAIL %s stall enables: pc_we=%0b fd_we=%0b expected=%0b",
                   it.tag, pc_we, fd_we, !it.stall);
        end
        @(posedge clk);
        #1;
        total++;
        if (ex_mr_mis(it) || ex_dst !== it.dst || ex_ctrl !== it.ctrl) begin
          bad++;
          $display("FAIL %s ex regs: mr=%0b dst=%0d ctrl=%h expected mr=%0b dst=%0d ctrl=%h",
                   it.tag, ex_mem_read, ex_dst, ex_ctrl, it.mr, it.dst, it.ctrl);
        end
      end
    end
  end

  function automatic bit ex_mr_mis(input item_t it);
    return ex_mem_read !== it.mr;
  endfunction

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #2;
    total++;
    if (pc_we !== 1'b1 || fd_we !== 1'b1 || ex_ctrl !== '0 || ex_mem_read !== 1'b0 || ex_dst !== '0) begin
      bad++;
      $display("FAIL R1 reset: pc_we=%0b fd_we=%0b ctrl=%h mr=%0b dst=%0d expected 1 1 0 0 0",
               pc_we, fd_we, ex_ctrl, ex_mem_read, ex_dst);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    total++;
    if (pc_we !== 1'b1 || ex_ctrl !== '0) begin
      bad++;
      $display("FAIL R1 after release: pc_we=%0b ctrl=%h expected 1 0", pc_we, ex_ctrl);
    end

    step(5'd1, 5'd2, 1, 1, 0, 5'd7, 8'h31, "R4 plain op");
    step(5'd7, 5'd2, 1, 1, 0, 5'd8, 8'h42, "R8 alu producer");
    step(5'd2, 5'd9, 1, 1, 1, 5'd3, 8'hA5, "R4 load issue");
    step(5'd3, 5'd4, 1, 1, 0, 5'd10, 8'h17, "R2 use rs");
    step(5'd3, 5'd4, 1, 1, 0, 5'd10, 8'h17, "R7 held retry");
    step(5'd1, 5'd1, 1, 1, 1, 5'd6, 8'hA1, "R4 load r6");
    step(5'd2, 5'd6, 1, 1, 0, 5'd11, 8'h5C, "R2 use rt");
    step(5'd2, 5'd6, 1, 1, 0, 5'd11, 8'h5C, "R7 held retry rt");
    step(5'd1, 5'd1, 1, 1, 1, 5'd12, 8'hA2, "R4 load r12");
    step(5'd4, 5'd12, 1, 0, 0, 5'd13, 8'h66, "R6 rt masked");
    step(5'd1, 5'd1, 1, 1, 1, 5'd14, 8'hA3, "R4 load r14");
    step(5'd14, 5'd2, 0, 1, 0, 5'd15, 8'h77, "R6 rs masked");
    step(5'd1, 5'd1, 1, 1, 1, 5'd0, 8'hA4, "R4 load r0");
    step(5'd0, 5'd0, 1, 1, 0, 5'd16, 8'h18, "R5 zero dst");
    step(5'd1, 5'd1, 1, 1, 1, 5'd20, 8'hA6, "R4 load r20");
    step(5'd20, 5'd3, 1, 0, 1, 5'd21, 8'hA7, "R2 load after load");
    step(5'd20, 5'd3, 1, 0, 1, 5'd21, 8'hA7, "R3 bubble then retry");
    step(5'd21, 5'd21, 1, 1, 0, 5'd22, 8'h29, "R2 both sources");
    step(5'd21, 5'd21, 1, 1, 0, 5'd22, 8'h29, "R7 both sources retry");
    step(5'd22, 5'd22, 1, 1, 0, 5'd23, 8'h3A, "R8 no load match");
    step(5'd0, 5'd0, 0, 0, 0, 5'd0, 8'h00, "R4 drain");

    wait (q.size() == 0);
    @(posedge clk);
    #5;
    finish_run();
  end
endmodule